// File: doc/BRIEF.md
# Ethernet receive address filter

This block decides, for every received Ethernet frame, whether it should be kept. It watches a byte-wide receive stream and collects the six destination address bytes that open each frame. One cycle after the address is complete it issues a registered accept or reject decision. That decision stays steady for the rest of the frame, so downstream logic can sample it at any time up to the next frame start.

A frame is accepted in any of these cases: its address equals the single programmed station address; it is the all-ones broadcast address; it is a multicast address whose hash bit is set in a 64-bit table; all-multicast mode is on and the frame is multicast; or promiscuous mode is on. The hash index is the low six bits of a bit-reflected CRC-32 that runs alongside the incoming address bytes, so no second pass over the address is needed. The station address, hash table and the two mode bits are written through a simple byte-wide register port.

Top module: `rx_addr_filter`

## Requirements
- R1: After reset, dec_valid and dec_accept are 0, and the station address, hash table and both mode bits are all zero.
- R2: A write with cfg_we=1 updates the target register from the next cycle. Addresses 0..5 hold station byte k, where byte 0 is the first byte on the wire. Addresses 8..15 hold hash table byte j. Address 16 is the control register: bit 0 is all-multicast and bit 1 is promiscuous. Writes to any other address change nothing.
- R3: The byte sampled with in_valid=1 and in_sof=1 is address byte 0. Later bytes are sampled with in_valid=1. If the sixth address byte is sampled at clock edge N, dec_valid is still 0 after edge N and becomes 1 at edge N+1, with dec_accept valid at that same edge.
- R4: A sampled start-of-frame byte clears dec_valid and dec_accept at that edge. Otherwise the decision holds unchanged: later payload bytes, frame end and register writes made after the decision do not alter it.
- R5: A unicast address (first byte bit 0 = 0) is accepted exactly when it equals the station address, unless promiscuous mode is on.
- R6: The broadcast address FF:FF:FF:FF:FF:FF is always accepted.
- R7: For a multicast address (first byte bit 0 = 1), a CRC register is set to 0xFFFFFFFF and updated over the six bytes, least significant bit first, with reflected polynomial 0xEDB88320 and no final inversion. Index h is CRC bits [5:0]. The frame is accepted when bit h&7 of hash byte h>>3 is 1.
- R8: With all-multicast on, every multicast address is accepted regardless of the hash table.
- R9: With promiscuous on, every frame with a full address is accepted.
- R10: A frame whose in_eof byte arrives before the sixth address byte is rejected, even in promiscuous mode. If that last byte is sampled at edge M, dec_valid=1 and dec_accept=0 appear at edge M+1.
- R11: Cycles with in_valid=0 do not advance the address collection. Bytes with in_valid=1 but no start-of-frame, arriving outside an address phase, produce no decision.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Receive byte strobe |
| in_sof | input | 1 | Marks the first byte of a frame |
| in_eof | input | 1 | Marks the last byte of a frame |
| in_data | input | 8 | Receive byte |
| cfg_we | input | 1 | Register write enable |
| cfg_addr | input | 5 | Register address |
| cfg_wdata | input | 8 | Register write data |
| dec_valid | output | 1 | Decision present for the current frame |
| dec_accept | output | 1 | 1 = accept, 0 = reject; meaningful while dec_valid=1 |

## Verification
On every cycle, the assertions check the following:
- the decision holds between frame starts and is cleared by a start;
- stray bytes outside an address phase never raise a completion;
- the collection counter stays in range;
- control writes land;
- broadcast and promiscuous decisions come out as accepts;
- short frames come out as rejects.

Whether the hash index, the station comparison and the all-multicast path choose correctly for a given address can only be shown by the bench. It compares each decision against a bit-serial CRC model across directed cases and randomly drawn addresses and table contents.

// File: rtl/afilt_pkg.sv
`timescale 1ns/1ps
// Package: shared constants, control type and the reflected CRC-32 byte step
// used by the receive address filter.
package afilt_pkg;

    localparam logic [31:0] CRC_SEED = 32'hFFFF_FFFF;
    localparam logic [31:0] CRC_POLY = 32'hEDB8_8320;

    typedef struct packed {
        logic promisc;
        logic all_multi;
    } filt_ctrl_t;

    // Advance a bit-reflected CRC-32 by one byte, least significant bit first.
    function automatic logic [31:0] crc_step_byte(input logic [31:0] cur, input logic [7:0] din);
        logic [31:0] r;
        r = cur;
        for (int i = 0; i < 8; i++) begin
            if (r[0] ^ din[i]) r = (r >> 1) ^ CRC_POLY;
            else               r = r >> 1;
        end
        return r;
    endfunction

endpackage

// File: rtl/afilt_regs.sv
`timescale 1ns/1ps
// Module: afilt_regs
// Holds the station address bytes, the hash table bytes and the control bits.
// Assumes single-cycle byte writes; there is no read path. The address map is
// derived from the parameters: station at 0, hash at the next power of two,
// control right after the hash window.
module afilt_regs
    import afilt_pkg::*;
#(
    parameter int ADDR_BYTES = 6,
    parameter int HASH_BYTES = 8,
    parameter int CFG_AW     = 5
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      cfg_we,
    input  logic [CFG_AW-1:0]         cfg_addr,
    input  logic [7:0]                cfg_wdata,
    output logic [8*ADDR_BYTES-1:0]   station,
    output logic [8*HASH_BYTES-1:0]   hash_tbl,
    output filt_ctrl_t                ctrl
);
    localparam int STA_BASE  = 0;
    localparam int HASH_BASE = 2 ** $clog2(ADDR_BYTES);
    localparam int CTRL_ADDR = HASH_BASE + 2 ** $clog2(HASH_BYTES);

    logic [7:0] sta_q  [ADDR_BYTES];
    logic [7:0] hash_q [HASH_BYTES];
    filt_ctrl_t ctrl_q;

    genvar g;
    generate
        for (g = 0; g < ADDR_BYTES; g++) begin : g_sta
            // Station byte g register.
            always_ff @(posedge clk) begin
                if (!rst_n)
                    sta_q[g] <= '0;
                else if (cfg_we && cfg_addr == CFG_AW'(STA_BASE + g))
                    sta_q[g] <= cfg_wdata;
            end
            assign station[8*g +: 8] = sta_q[g];
        end
        for (g = 0; g < HASH_BYTES; g++) begin : g_hash
            // Hash table byte g register.
            always_ff @(posedge clk) begin
                if (!rst_n)
                    hash_q[g] <= '0;
                else if (cfg_we && cfg_addr == CFG_AW'(HASH_BASE + g))
                    hash_q[g] <= cfg_wdata;
            end
            assign hash_tbl[8*g +: 8] = hash_q[g];
        end
    endgenerate

    // Control register: bit 0 all-multicast, bit 1 promiscuous.
    always_ff @(posedge clk) begin
        if (!rst_n)
            ctrl_q <= '0;
        else if (cfg_we && cfg_addr == CFG_AW'(CTRL_ADDR))
            ctrl_q <= '{promisc: cfg_wdata[1], all_multi: cfg_wdata[0]};
    end
    assign ctrl = ctrl_q;

    assert_ctrl_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_we && cfg_addr == CFG_AW'(CTRL_ADDR)) |=>
            (ctrl.promisc == $past(cfg_wdata[1]) && ctrl.all_multi == $past(cfg_wdata[0])));

endmodule

// File: rtl/afilt_capture.sv
`timescale 1ns/1ps
// Module: afilt_capture
// Collects the destination address bytes of each frame and runs the reflected
// CRC-32 over them. Pulses addr_done one cycle after the last address byte and
// short_done when the frame ends early. Assumes in_sof only with in_valid.
module afilt_capture
    import afilt_pkg::*;
#(
    parameter int ADDR_BYTES = 6,
    parameter int HIDX_W     = 6
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     in_valid,
    input  logic                     in_sof,
    input  logic                     in_eof,
    input  logic [7:0]               in_data,
    output logic [8*ADDR_BYTES-1:0]  addr_q,
    output logic [HIDX_W-1:0]        hash_idx,
    output logic                     addr_done,
    output logic                     short_done
);
    localparam int CNT_W = $clog2(ADDR_BYTES);
    localparam int LAST  = ADDR_BYTES - 1;

    logic [CNT_W-1:0] cnt;      // next byte index; 0 means not collecting
    logic [CNT_W-1:0] wr_idx;
    logic             take;
    logic [31:0]      crc_q;
    logic [7:0]       byte_q [ADDR_BYTES];

    assign wr_idx = in_sof ? '0 : cnt;
    assign take   = in_valid && (in_sof || cnt != '0);

    genvar g;
    generate
        for (g = 0; g < ADDR_BYTES; g++) begin : g_byte
            // Address byte g capture.
            always_ff @(posedge clk) begin
                if (!rst_n)
                    byte_q[g] <= '0;
                else if (take && wr_idx == CNT_W'(g))
                    byte_q[g] <= in_data;
            end
            assign addr_q[8*g +: 8] = byte_q[g];
        end
    endgenerate

    // Byte counter, CRC accumulation and completion pulses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt        <= '0;
            crc_q      <= CRC_SEED;
            addr_done  <= 1'b0;
            short_done <= 1'b0;
        end else begin
            addr_done  <= 1'b0;
            short_done <= 1'b0;
            if (take) begin
                crc_q <= crc_step_byte(in_sof ? CRC_SEED : crc_q, in_data);
                if (wr_idx == CNT_W'(LAST)) begin
                    cnt       <= '0;
                    addr_done <= 1'b1;
                end else if (in_eof) begin
                    cnt        <= '0;
                    short_done <= 1'b1;
                end else begin
                    cnt <= wr_idx + CNT_W'(1);
                end
            end
        end
    end

    assign hash_idx = crc_q[HIDX_W-1:0];

    assert_cnt_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
        cnt < CNT_W'(ADDR_BYTES));

    assert_stray_byte_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !in_sof && cnt == '0) |=> (!addr_done && !short_done));

endmodule

// File: rtl/afilt_decide.sv
`timescale 1ns/1ps
// Module: afilt_decide
// Turns a completed address into a registered accept/reject decision and holds
// it until the next frame start. Assumes addr_done/short_done are one-cycle
// pulses from the capture stage.
module afilt_decide
    import afilt_pkg::*;
#(
    parameter int ADDR_BYTES = 6,
    parameter int HASH_BITS  = 64,
    parameter int HIDX_W     = 6
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     frame_start,
    input  logic                     addr_done,
    input  logic                     short_done,
    input  logic [8*ADDR_BYTES-1:0]  addr_q,
    input  logic [HIDX_W-1:0]        hash_idx,
    input  logic [8*ADDR_BYTES-1:0]  station,
    input  logic [HASH_BITS-1:0]     hash_tbl,
    input  filt_ctrl_t               ctrl,
    output logic                     dec_valid,
    output logic                     dec_accept
);
    logic is_bcast, is_mcast, is_match, hash_hit, verdict;

    // Address classification and acceptance rule.
    always_comb begin
        is_bcast = &addr_q;
        is_mcast = addr_q[0];
        is_match = (addr_q == station);
        hash_hit = hash_tbl[hash_idx];
        verdict  = ctrl.promisc || is_bcast ||
                   (is_mcast ? (ctrl.all_multi || hash_hit) : is_match);
    end

    // Decision register: cleared by frame start, loaded on completion.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dec_valid  <= 1'b0;
            dec_accept <= 1'b0;
        end else if (frame_start) begin
            dec_valid  <= 1'b0;
            dec_accept <= 1'b0;
        end else if (addr_done) begin
            dec_valid  <= 1'b1;
            dec_accept <= verdict;
        end else if (short_done) begin
            dec_valid  <= 1'b1;
            dec_accept <= 1'b0;
        end
    end

    assert_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_valid && !frame_start) |=> (dec_valid && $stable(dec_accept)));

    assert_clear_R4: assert property (@(posedge clk) disable iff (!rst_n)
        frame_start |=> (!dec_valid && !dec_accept));

    assert_promisc_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(dec_valid) && $past(addr_done) && $past(ctrl.promisc)) |-> dec_accept);

    assert_bcast_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(dec_valid) && $past(addr_done) && $past(&addr_q)) |-> dec_accept);

    assert_short_R10: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(short_done) && !$past(frame_start)) |-> (dec_valid && !dec_accept));

endmodule

// File: rtl/rx_addr_filter.sv
`timescale 1ns/1ps
// Module: rx_addr_filter
// Receive address filter top: register file, address capture with CRC, and
// decision stage. Assumes a byte stream with in_sof/in_eof qualified by in_valid.
module rx_addr_filter
    import afilt_pkg::*;
#(
    parameter int ADDR_BYTES = 6,
    parameter int HASH_BITS  = 64,
    parameter int CFG_AW     = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic              in_sof,
    input  logic              in_eof,
    input  logic [7:0]        in_data,
    input  logic              cfg_we,
    input  logic [CFG_AW-1:0] cfg_addr,
    input  logic [7:0]        cfg_wdata,
    output logic              dec_valid,
    output logic              dec_accept
);
    localparam int HASH_BYTES = HASH_BITS / 8;
    localparam int HIDX_W     = $clog2(HASH_BITS);

    logic [8*ADDR_BYTES-1:0] station, addr_q;
    logic [HASH_BITS-1:0]    hash_tbl;
    logic [HIDX_W-1:0]       hash_idx;
    filt_ctrl_t              ctrl;
    logic                    addr_done, short_done, frame_start;

    assign frame_start = in_valid && in_sof;

    afilt_regs #(.ADDR_BYTES(ADDR_BYTES), .HASH_BYTES(HASH_BYTES), .CFG_AW(CFG_AW)) u_regs (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .station(station), .hash_tbl(hash_tbl), .ctrl(ctrl)
    );

    afilt_capture #(.ADDR_BYTES(ADDR_BYTES), .HIDX_W(HIDX_W)) u_capture (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sof(in_sof),
        .in_eof(in_eof), .in_data(in_data), .addr_q(addr_q), .hash_idx(hash_idx),
        .addr_done(addr_done), .short_done(short_done)
    );

    afilt_decide #(.ADDR_BYTES(ADDR_BYTES), .HASH_BITS(HASH_BITS), .HIDX_W(HIDX_W)) u_decide (
        .clk(clk), .rst_n(rst_n), .frame_start(frame_start), .addr_done(addr_done),
        .short_done(short_done), .addr_q(addr_q), .hash_idx(hash_idx),
        .station(station), .hash_tbl(hash_tbl), .ctrl(ctrl),
        .dec_valid(dec_valid), .dec_accept(dec_accept)
    );

endmodule

// File: tb/test_rx_addr_filter.sv
`timescale 1ns/1ps
// Bench: directed corner cases plus seeded random frames, checked against a
// bit-serial reference model of the acceptance rule.
module test_rx_addr_filter;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       in_valid = 1'b0, in_sof = 1'b0, in_eof = 1'b0;
    logic [7:0] in_data = '0;
    logic       cfg_we = 1'b0;
    logic [4:0] cfg_addr = '0;
    logic [7:0] cfg_wdata = '0;
    logic       dec_valid, dec_accept;

    int n_cmp = 0;
    int n_bad = 0;

    logic [47:0] m_sta  = '0;
    logic [63:0] m_hash = '0;
    bit          m_am = 0, m_pr = 0;

    always #10 clk = ~clk;

    rx_addr_filter i_rx_addr_filter (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sof(in_sof),
        .in_eof(in_eof), .in_data(in_data), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .dec_valid(dec_valid), .dec_accept(dec_accept)
    );

    function automatic logic [31:0] ref_crc(input logic [47:0] da);
        logic [31:0] c;
        logic        fb;
        c = 32'hFFFF_FFFF;
        for (int k = 0; k < 48; k++) begin
            fb = c[0] ^ da[k];
            c  = {1'b0, c[31:1]};
            if (fb) c = c ^ 32'hEDB8_8320;
        end
        return c;
    endfunction

    function automatic logic ref_accept(input logic [47:0] da);
        logic [31:0] c;
        c = ref_crc(da);
        if (m_pr) return 1'b1;
        if (&da) return 1'b1;
        if (da[0]) return m_am | m_hash[c[5:0]];
        return da == m_sta;
    endfunction

    function automatic string tag_of(input logic [47:0] da);
        if (m_pr) return "R9";
        if (&da) return "R6";
        if (da[0]) return m_am ? "R8" : "R7";
        return "R5";
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic step(input logic v, input logic s, input logic e, input logic [7:0] d);
        @(negedge clk);
        in_valid = v; in_sof = s; in_eof = e; in_data = d;
        @(posedge clk);
        #1;
    endtask

    task automatic idle();
        step(1'b0, 1'b0, 1'b0, 8'h00);
    endtask

    task automatic wr(input logic [4:0] a, input logic [7:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
        if (a < 5'd6) m_sta[8*a +: 8] = d;
        else if (a >= 5'd8 && a < 5'd16) m_hash[8*(a-8) +: 8] = d;
        else if (a == 5'd16) begin m_am = d[0]; m_pr = d[1]; end
    endtask

    task automatic set_station(input logic [47:0] s);
        for (int i = 0; i < 6; i++) wr(5'(i), s[8*i +: 8]);
    endtask

    task automatic send_frame(input logic [47:0] da, input int extra, input bit gaps);
        logic  exp;
        string t;
        exp = ref_accept(da);
        t   = tag_of(da);
        for (int i = 0; i < 6; i++) begin
            if (gaps && i > 0 && $urandom_range(0, 2) == 0) idle();
            step(1'b1, i == 0, (i == 5 && extra == 0), da[8*i +: 8]);
            if (i == 0) check("R4 clear on start", {31'd0, dec_valid}, 0);
            if (i == 5) check("R3 not yet valid", {31'd0, dec_valid}, 0);
        end
        if (extra > 0) step(1'b1, 1'b0, extra == 1, 8'($urandom));
        else idle();
        check("R3 valid timing", {31'd0, dec_valid}, 1);
        check(t, {31'd0, dec_accept}, {31'd0, exp});
        for (int j = 1; j < extra; j++) step(1'b1, 1'b0, j == extra - 1, 8'($urandom));
        idle();
        check("R4 hold valid", {31'd0, dec_valid}, 1);
        check("R4 hold accept", {31'd0, dec_accept}, {31'd0, exp});
    endtask

    task automatic send_short(input logic [47:0] da, input int n);
        for (int i = 0; i < n; i++) step(1'b1, i == 0, i == n - 1, da[8*i +: 8]);
        check("R10 short not yet", {31'd0, dec_valid}, 0);
        idle();
        check("R10 short valid", {31'd0, dec_valid}, 1);
        check("R10 short reject", {31'd0, dec_accept}, 0);
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (150000) @(posedge clk);
        n_cmp++; n_bad++;
        $display("FAIL watchdog R3 actual=hung expected=done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        logic [47:0] da;
        logic [31:0] c;
        int unsigned seed;
        seed = $urandom(32'd20251);
        repeat (3) @(posedge clk);
        #1;
        check("R1 reset valid", {31'd0, dec_valid}, 0);
        check("R1 reset accept", {31'd0, dec_accept}, 0);
        @(negedge clk);
        rst_n = 1'b1;

        // R1: cleared station matches the all-zero address; empty hash rejects.
        send_frame(48'h0, 0, 0);
        send_frame(48'h0000_0000_0001, 0, 0);

        // R11: stray bytes with no start give no decision after a decision; and idle gaps.
        step(1'b1, 1'b0, 1'b0, 8'hAA);
        step(1'b1, 1'b0, 1'b1, 8'h55);
        check("R11 stray bytes keep decision", {31'd0, dec_valid}, 1);

        // R2/R5: program station, exact and near matches.
        set_station(48'hBC9A_7856_3402);
        send_frame(48'hBC9A_7856_3402, 3, 0);
        send_frame(48'hBC9A_7856_3502, 0, 0);
        send_frame(48'h3C9A_7856_3402, 2, 1);

        // R2: writes outside the map change nothing.
        wr(5'd6, 8'hFF); wr(5'd7, 8'h11); wr(5'd20, 8'h03); wr(5'd31, 8'h02);
        send_frame(48'hBC9A_7856_3402, 0, 0);
        check("R2 ignored writes", {31'd0, dec_accept}, 1);

        // R6 broadcast.
        send_frame(48'hFFFF_FFFF_FFFF, 1, 1);

        // R7: set exactly the hash bit of one multicast address.
        da = 48'h0100_5E00_0001 | 48'h01;
        da = 48'h0100005E0001;
        da[0] = 1'b1;
        c = ref_crc(da);
        wr(5'(8 + c[5:3]), 8'(1 << c[2:0]));
        send_frame(da, 0, 0);
        check("R7 hash hit", {31'd0, dec_accept}, 1);
        wr(5'(8 + c[5:3]), 8'(~(1 << c[2:0])));
        send_frame(da, 0, 0);
        check("R7 hash miss", {31'd0, dec_accept}, 0);

        // R8 all-multicast.
        wr(5'd16, 8'h01);
        send_frame(da, 0, 0);
        send_frame(48'h0000_0000_0003, 0, 1);

        // R4: register change after decision does not alter it.
        wr(5'd16, 8'h00);
        send_frame(48'h1234_5678_9A00, 0, 0);
        wr(5'd16, 8'h02);
        idle();
        check("R4 config after decision", {31'd0, dec_accept}, 0);

        // R9 promiscuous, then R10 short frames even in promiscuous mode.
        send_frame(48'h1234_5678_9A00, 0, 0);
        send_short(48'hBC9A_7856_3402, 1);
        send_short(48'hFFFF_FFFF_FFFF, 3);
        send_short(48'hBC9A_7856_3402, 5);
        wr(5'd16, 8'h00);

        // R3: a new start mid-address restarts collection.
        step(1'b1, 1'b1, 1'b0, 8'h02);
        step(1'b1, 1'b0, 1'b0, 8'h34);
        step(1'b1, 1'b0, 1'b0, 8'h56);
        send_frame(48'hBC9A_7856_3402, 0, 1);
        check("R3 restart on start", {31'd0, dec_accept}, 1);

        // Random frames against the model.
        for (int n = 0; n < 400; n++) begin
            if (n % 25 == 0) begin
                for (int b = 0; b < 8; b++) wr(5'(8 + b), 8'($urandom));
                wr(5'd16, {6'd0, ($urandom % 7) == 0, ($urandom % 5) == 0});
            end
            case ($urandom % 5)
                0: da = m_sta;
                1: da = 48'hFFFF_FFFF_FFFF;
                2: begin da = {$urandom, $urandom} ; da[0] = 1'b1; end
                3: begin da = {$urandom, $urandom}; da[0] = 1'b0; end
                default: begin da = m_sta; da[8*($urandom % 6) +: 8] ^= 8'h10; end
            endcase
            send_frame(da, int'($urandom % 5), bit'($urandom % 2));
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule